// File: doc/BRIEF.md
# Flash Erase/Program Timing Sequencer

This block sits between a register bus and an embedded NOR flash macro. Software loads the timing fields, the target address and the protection state, then writes a command bit into the control register. Five operations are offered: whole-array erase, page erase, program, reference-cell erase and trim-code recall. Every operation walks through three timed phases in a fixed order: setup, active and a non-volatile hold. Each phase lasts a number of clock cycles taken from the timing registers. While the sequence runs, a busy flag reads as 1. The command bit clears itself when the hold phase ends.

Register changes can be locked by a protect bit. That bit can only be changed by a control write that follows a three-write unlock sequence. A write that protection blocks has no effect and raises a sticky error flag, which software clears by writing 1 to it. The bus is a plain one-cycle write strobe with a combinational read port. No data stream passes through the block, so there is no back-pressure.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, busy and all operation strobes are 0, and the control and status registers read as 0.
- R2: An accepted command sets busy for exactly S+A+H cycles and then clears it. S is timing2 bits 23:16, H is timing0 bits 31:16, and A is the active count. A field value of 0 counts as 1.
- R3: The strobe of the chosen operation is high only during the active phase, for exactly A cycles. Strobe bit 0 is mass erase, 1 is page erase, 2 is program, 3 is reference erase and 4 is recall. A is timing1 bits 23:0 for the three erases, timing2 bits 15:0 for program and timing2 bits 27:24 for recall.
- R4: Control bits 3..7 are mass erase, page erase, program, reference erase and recall. When one write sets several of them, only the lowest-numbered bit is kept and run.
- R5: The running command's bit reads back as 1 in the control register until the operation completes, and then reads as 0.
- R6: A control write while busy is 1 is ignored completely. This includes a write on the cycle in which the hold phase ends.
- R7: While control bit 1 (protect) is 1, writes to timing0/1/2 (0x04/0x08/0x0C), to address (0x20) and to control are ignored, and status bit 1 is set. Status bit 0 is busy.
- R8: Control bit 1 changes only on the control write that follows the unlock writes 0x7123 to 0x18, 0x812A to 0x1C and 0xBEE1 to 0x18, in that order. Any other write in between cancels the sequence.
- R9: Writing status (0x2C) with bit 1 = 1 clears the error flag. Writing it with bit 1 = 0 leaves the flag unchanged.
- R10: The flash address output equals the 20-bit address register. During page erase the low 12 bits are forced to 0 (4096-byte pages).
- R11: Timing registers read back only their defined fields: timing0 bits 31:16 and 5:0, timing1 bits 23:0, timing2 bits 27:0. Status bits 2, 3 and 4 reflect flag inputs 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| flash_flags | input | 3 | Macro flags: redundancy off, discharged, brown-out |
| busy | output | 1 | Operation in progress |
| op_strobe | output | 5 | One-hot operation strobe to the macro |
| flash_addr | output | 20 | Address presented to the macro |
| sleep_mode | output | 1 | Sleep request to the macro |
| rd_wait | output | 6 | Read wait states for the macro |

## Verification
The hold phase can finish on the same clock edge that a new control write arrives. In that case the finishing operation must win, and the write must be dropped. The bench provokes this by counting the known busy length of a recall and placing a mass-erase write exactly on the final edge. It then judges the result by checking three things: the scoreboard receives no extra operation, busy stays low afterward, and the control register reads back with no command bit set.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int NUM_OPS = 5;
  localparam int SU_W    = 8;
  localparam int SH_W    = 4;
  localparam int PG_W    = 16;
  localparam int ER_W    = 24;
  localparam int HD_W    = 16;
  localparam int WS_W    = 6;
  localparam int CNT_W   = ER_W;

  localparam logic [5:0] OFS_CTRL  = 6'h00;
  localparam logic [5:0] OFS_T0    = 6'h04;
  localparam logic [5:0] OFS_T1    = 6'h08;
  localparam logic [5:0] OFS_T2    = 6'h0C;
  localparam logic [5:0] OFS_ULK_A = 6'h18;
  localparam logic [5:0] OFS_ULK_B = 6'h1C;
  localparam logic [5:0] OFS_ADDR  = 6'h20;
  localparam logic [5:0] OFS_STAT  = 6'h2C;

  localparam int CB_SLEEP = 0;
  localparam int CB_WP    = 1;
  localparam int CB_CMD   = 3;
  localparam int CB_AUTO  = 8;

  // op index inside the one-hot command vector
  localparam int OP_MASS = 0;
  localparam int OP_PAGE = 1;
  localparam int OP_PROG = 2;
  localparam int OP_REF  = 3;
  localparam int OP_RCL  = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD} phase_t;

  // keep the lowest set bit: mass erase has the highest priority
  function automatic logic [NUM_OPS-1:0] pick_cmd(input logic [NUM_OPS-1:0] r);
    return r & (~r + NUM_OPS'(1));
  endfunction
endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= (load_val == '0) ? W'(1) : load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign expire = (cnt_q == W'(1));

  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NUM_OPS-1:0] cmd_oh,
  input  logic [SU_W-1:0]    setup_cnt,
  input  logic [ER_W-1:0]    erase_cnt,
  input  logic [PG_W-1:0]    prog_cnt,
  input  logic [SH_W-1:0]    recall_cnt,
  input  logic [HD_W-1:0]    hold_cnt,
  output logic               busy,
  output logic               done,
  output logic [NUM_OPS-1:0] strobe
);
  phase_t            ph_q, ph_d;
  logic              load, expire;
  logic [CNT_W-1:0]  load_val, active_val;

  always_comb begin
    if (cmd_oh[OP_PROG])     active_val = CNT_W'(prog_cnt);
    else if (cmd_oh[OP_RCL]) active_val = CNT_W'(recall_cnt);
    else                     active_val = CNT_W'(erase_cnt);
  end

  always_comb begin
    ph_d = ph_q;
    load = 1'b0;
    load_val = '0;
    unique case (ph_q)
      PH_IDLE:   if (start)  begin ph_d = PH_SETUP;  load = 1'b1; load_val = CNT_W'(setup_cnt); end
      PH_SETUP:  if (expire) begin ph_d = PH_ACTIVE; load = 1'b1; load_val = active_val; end
      PH_ACTIVE: if (expire) begin ph_d = PH_HOLD;   load = 1'b1; load_val = CNT_W'(hold_cnt); end
      PH_HOLD:   if (expire) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  fseq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
  );

  assign busy   = (ph_q != PH_IDLE);
  assign done   = (ph_q == PH_HOLD) && expire;
  assign strobe = (ph_q == PH_ACTIVE) ? cmd_oh : '0;

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  assert_active_has_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACTIVE) |-> $onehot(cmd_oh));
  assert_done_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/fseq_regs.sv
module fseq_regs
  import fseq_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter logic [31:0] KEY_A  = 32'h0000_7123,
  parameter logic [31:0] KEY_B  = 32'h0000_812A,
  parameter logic [31:0] KEY_C  = 32'h0000_BEE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [2:0]         flags_in,
  input  logic               busy,
  input  logic               done,
  output logic               start,
  output logic [NUM_OPS-1:0] cmd_oh,
  output logic               sleep,
  output logic [WS_W-1:0]    wait_states,
  output logic [HD_W-1:0]    hold_cnt,
  output logic [ER_W-1:0]    erase_cnt,
  output logic [PG_W-1:0]    prog_cnt,
  output logic [SU_W-1:0]    setup_cnt,
  output logic [SH_W-1:0]    recall_cnt,
  output logic [ADDR_W-1:0]  addr_q
);
  logic               wp_q, auto_q, sleep_q, wer_q;
  logic [NUM_OPS-1:0] cmd_q, pick;
  logic [1:0]         ulk_q;
  logic               wr_ctrl, wr_t0, wr_t1, wr_t2, wr_addr, wr_stat, armed, ctrl_ok, prot_hit;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_t0    = bus_wr && (bus_addr == OFS_T0);
  assign wr_t1    = bus_wr && (bus_addr == OFS_T1);
  assign wr_t2    = bus_wr && (bus_addr == OFS_T2);
  assign wr_addr  = bus_wr && (bus_addr == OFS_ADDR);
  assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
  assign armed    = (ulk_q == 2'd3);
  assign ctrl_ok  = wr_ctrl && !busy && (!wp_q || armed);
  assign prot_hit = wp_q && ((wr_ctrl && !busy && !armed) || wr_t0 || wr_t1 || wr_t2 || wr_addr);
  assign pick     = pick_cmd(bus_wdata[CB_CMD +: NUM_OPS]);
  assign start    = ctrl_ok && (pick != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {wp_q, auto_q, sleep_q, wer_q} <= '0;
      cmd_q <= '0;
      ulk_q <= '0;
      {hold_cnt, wait_states, erase_cnt, prog_cnt, setup_cnt, recall_cnt} <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_ok) begin
        sleep_q <= bus_wdata[CB_SLEEP];
        auto_q  <= bus_wdata[CB_AUTO];
        if (armed) wp_q <= bus_wdata[CB_WP];
        cmd_q   <= pick;
      end else if (done) begin
        cmd_q   <= '0;
      end
      if (bus_wr) begin
        if (wr_ctrl)                                                          ulk_q <= 2'd0;
        else if (bus_addr == OFS_ULK_A && bus_wdata == KEY_A && ulk_q == 2'd0) ulk_q <= 2'd1;
        else if (bus_addr == OFS_ULK_B && bus_wdata == KEY_B && ulk_q == 2'd1) ulk_q <= 2'd2;
        else if (bus_addr == OFS_ULK_A && bus_wdata == KEY_C && ulk_q == 2'd2) ulk_q <= 2'd3;
        else                                                                  ulk_q <= 2'd0;
      end
      if (!wp_q) begin
        if (wr_t0)   begin hold_cnt <= bus_wdata[31:16]; wait_states <= bus_wdata[WS_W-1:0]; end
        if (wr_t1)   erase_cnt <= bus_wdata[ER_W-1:0];
        if (wr_t2)   begin
          prog_cnt   <= bus_wdata[PG_W-1:0];
          setup_cnt  <= bus_wdata[16 +: SU_W];
          recall_cnt <= bus_wdata[24 +: SH_W];
        end
        if (wr_addr) addr_q <= bus_wdata[ADDR_W-1:0];
      end
      if (prot_hit)                     wer_q <= 1'b1;
      else if (wr_stat && bus_wdata[1]) wer_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = 32'({auto_q, cmd_q, 1'b0, wp_q, sleep_q});
      OFS_T0:   bus_rdata = {hold_cnt, 10'b0, wait_states};
      OFS_T1:   bus_rdata = 32'(erase_cnt);
      OFS_T2:   bus_rdata = {4'b0, recall_cnt, setup_cnt, prog_cnt};
      OFS_ADDR: bus_rdata = 32'(addr_q);
      OFS_STAT: bus_rdata = 32'({flags_in, wer_q, busy});
      default:  bus_rdata = '0;
    endcase
  end

  assign cmd_oh = cmd_q;
  assign sleep  = sleep_q;

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_busy_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> $stable({auto_q, wp_q, sleep_q}));
  assert_prot_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q && wr_t1) |=> $stable(erase_cnt));
  assert_cmd_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cmd_q == '0));
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import fseq_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          PAGE_BYTES = 4096,
  parameter logic [31:0] KEY_A      = 32'h0000_7123,
  parameter logic [31:0] KEY_B      = 32'h0000_812A,
  parameter logic [31:0] KEY_C      = 32'h0000_BEE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [2:0]         flash_flags,
  output logic               busy,
  output logic [NUM_OPS-1:0] op_strobe,
  output logic [ADDR_W-1:0]  flash_addr,
  output logic               sleep_mode,
  output logic [WS_W-1:0]    rd_wait
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic               start, done;
  logic [NUM_OPS-1:0] cmd_oh;
  logic [HD_W-1:0]    hold_cnt;
  logic [ER_W-1:0]    erase_cnt;
  logic [PG_W-1:0]    prog_cnt;
  logic [SU_W-1:0]    setup_cnt;
  logic [SH_W-1:0]    recall_cnt;
  logic [ADDR_W-1:0]  addr_q;

  fseq_regs #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags_in(flash_flags),
    .busy(busy), .done(done), .start(start), .cmd_oh(cmd_oh), .sleep(sleep_mode),
    .wait_states(rd_wait), .hold_cnt(hold_cnt), .erase_cnt(erase_cnt),
    .prog_cnt(prog_cnt), .setup_cnt(setup_cnt), .recall_cnt(recall_cnt), .addr_q(addr_q)
  );

  fseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_oh(cmd_oh),
    .setup_cnt(setup_cnt), .erase_cnt(erase_cnt), .prog_cnt(prog_cnt),
    .recall_cnt(recall_cnt), .hold_cnt(hold_cnt),
    .busy(busy), .done(done), .strobe(op_strobe)
  );

  assign flash_addr = cmd_oh[OP_PAGE] ? (addr_q & ~PAGE_MASK) : addr_q;
endmodule

// File: tb/sim_flash_op_sequencer.sv
`timescale 1ns/1ps
module sim_flash_op_sequencer;
  localparam logic [5:0] A_CTRL = 6'h00, A_T0 = 6'h04, A_T1 = 6'h08, A_T2 = 6'h0C;
  localparam logic [5:0] A_UA = 6'h18, A_UB = 6'h1C, A_ADDR = 6'h20, A_STAT = 6'h2C;

  typedef struct packed {
    logic [4:0]  so;
    logic [31:0] act;
    logic [31:0] tot;
    logic [19:0] ad;
  } exp_t;

  logic        clk = 0, rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  flash_flags;
  logic        busy, sleep_mode;
  logic [4:0]  op_strobe;
  logic [19:0] flash_addr;
  logic [5:0]  rd_wait;

  int checks = 0, errors = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  flash_op_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_flags(flash_flags),
    .busy(busy), .op_strobe(op_strobe), .flash_addr(flash_addr),
    .sleep_mode(sleep_mode), .rd_wait(rd_wait)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == expv, tag, bus_rdata, expv);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [4:0] so, input int act, input int tot, input logic [19:0] ad);
    exp_t e;
    e.so = so; e.act = act; e.tot = tot; e.ad = ad;
    exp_q.push_back(e);
  endtask

  // monitor: measures each busy window and compares it with the scoreboard
  bit in_op = 0, stray = 0;
  int n_busy, n_act;
  logic [4:0] seen;
  logic [19:0] a_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!in_op) begin
          in_op = 1; n_busy = 0; n_act = 0; seen = '0; a_seen = '0;
          stray = (exp_q.size() == 0);
          if (stray) chk(0, "R6 unexpected operation started", 1, 0);
        end
        n_busy++;
        if (op_strobe != '0) begin n_act++; seen |= op_strobe; a_seen = flash_addr; end
      end else if (in_op) begin
        in_op = 0;
        if (!stray) begin
          exp_t e;
          e = exp_q.pop_front();
          chk(n_busy == e.tot, "R2 busy length", n_busy, e.tot);
          chk(n_act == e.act, "R3 strobe length", n_act, e.act);
          chk(seen == e.so, "R3 strobe select", 32'(seen), 32'(e.so));
          chk(a_seen == e.ad, "R10 flash address", 32'(a_seen), 32'(e.ad));
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_wr = 0; bus_addr = '0; bus_wdata = '0; flash_flags = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(op_strobe == 0, "R1 strobe after reset", op_strobe, 0);
    rd_chk(A_CTRL, 0, "R1 control after reset");
    rd_chk(A_STAT, 0, "R1 status after reset");
    rst_n = 1;

    // R11 field masks
    wr(A_T1, 32'hFFFF_FFFF); rd_chk(A_T1, 32'h00FF_FFFF, "R11 timing1 mask");
    wr(A_T0, 32'hFFFF_FFFF); rd_chk(A_T0, 32'hFFFF_003F, "R11 timing0 mask");
    wr(A_T2, 32'hFFFF_FFFF); rd_chk(A_T2, 32'h0FFF_FFFF, "R11 timing2 mask");
    wr(A_T0, (32'd3 << 16) | 32'd5);
    chk(rd_wait == 6'd5, "R11 wait states out", rd_wait, 5);
    wr(A_T1, 32'd6);
    wr(A_T2, (32'd2 << 24) | (32'd2 << 16) | 32'd4);
    wr(A_ADDR, 32'hFFF1_2345); rd_chk(A_ADDR, 32'h0001_2345, "R10 address width");

    // each operation: setup 2, hold 3
    push(5'b00010, 6, 11, 20'h12000);
    wr(A_CTRL, 32'h10);
    rd_chk(A_CTRL, 32'h10, "R5 page bit while running");
    wait_idle();
    rd_chk(A_CTRL, 32'h0, "R5 bit cleared after page erase");
    push(5'b00100, 4, 9, 20'h12345);  wr(A_CTRL, 32'h20); wait_idle();
    push(5'b00001, 6, 11, 20'h12345); wr(A_CTRL, 32'h08); wait_idle();
    push(5'b01000, 6, 11, 20'h12345); wr(A_CTRL, 32'h40); wait_idle();
    push(5'b10000, 2, 7, 20'h12345);  wr(A_CTRL, 32'h80); wait_idle();

    // R4 priority
    push(5'b00001, 6, 11, 20'h12345); wr(A_CTRL, 32'hF8);
    rd_chk(A_CTRL, 32'h08, "R4 mass erase wins"); wait_idle();
    push(5'b00100, 4, 9, 20'h12345); wr(A_CTRL, 32'hA0);
    rd_chk(A_CTRL, 32'h20, "R4 program beats recall"); wait_idle();

    // R6 write while busy
    push(5'b00010, 6, 11, 20'h12000); wr(A_CTRL, 32'h10);
    repeat (3) @(posedge clk);
    wr(A_CTRL, 32'h09);
    rd_chk(A_CTRL, 32'h10, "R6 mid-run write dropped");
    chk(sleep_mode == 0, "R6 sleep unchanged", sleep_mode, 0);
    wait_idle();

    // R6 write on the completion edge (recall busy length 7)
    push(5'b10000, 2, 7, 20'h12345); wr(A_CTRL, 32'h80);
    repeat (6) @(posedge clk);
    wr(A_CTRL, 32'h08);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R6 completion-edge write dropped", busy, 0);
    rd_chk(A_CTRL, 32'h0, "R6 control after completion edge");

    // R8 protect needs unlock
    wr(A_CTRL, 32'h2); rd_chk(A_CTRL, 32'h0, "R8 protect bit held without unlock");
    wr(A_UA, 32'h7123); wr(A_UB, 32'h812A); wr(A_UA, 32'hBEE1); wr(A_CTRL, 32'h2);
    rd_chk(A_CTRL, 32'h2, "R8 protect set after unlock");

    // R7 protected writes
    wr(A_T1, 32'h99); rd_chk(A_T1, 32'd6, "R7 timing1 frozen");
    rd_chk(A_STAT, 32'h2, "R7 error flag set");
    wr(A_ADDR, 32'h0); rd_chk(A_ADDR, 32'h12345, "R7 address frozen");
    wr(A_CTRL, 32'h08);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R7 protected command not run", busy, 0);
    rd_chk(A_CTRL, 32'h2, "R7 control frozen");

    // R9 error clear
    wr(A_STAT, 32'h0); rd_chk(A_STAT, 32'h2, "R9 write 0 keeps flag");
    wr(A_STAT, 32'h2); rd_chk(A_STAT, 32'h0, "R9 write 1 clears flag");

    // R8 broken sequence
    wr(A_UA, 32'h7123); wr(A_UB, 32'h0); wr(A_UA, 32'hBEE1); wr(A_CTRL, 32'h0);
    rd_chk(A_CTRL, 32'h2, "R8 wrong key keeps protect");
    rd_chk(A_STAT, 32'h2, "R8 wrong key raises error");
    wr(A_STAT, 32'h2);
    wr(A_UA, 32'h7123); wr(A_UB, 32'h812A); wr(A_UA, 32'hBEE1); wr(A_CTRL, 32'h0);
    rd_chk(A_CTRL, 32'h0, "R8 protect cleared after unlock");

    // R11 flags
    flash_flags = 3'b101;
    rd_chk(A_STAT, 32'h14, "R11 status flag bits");
    flash_flags = 3'b000;

    // R2 zero setup field counts as one
    wr(A_T2, (32'd2 << 24) | 32'd4);
    push(5'b00100, 4, 8, 20'h12345); wr(A_CTRL, 32'h20); wait_idle();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected operations seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule